// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

The block keeps two banks of event counters for an Ethernet MAC, one bank for transmitted frames and one for received frames. Each frame produces one 26-bit statistics vector. Its low 14 bits hold the frame's byte count, and its upper 12 bits are event flags such as errors, address class, tagging and control-frame origin. When the vector's valid strobe is high for one cycle, every counter whose flag is set in the vector goes up by one. In the same cycle the byte counter adds the byte-count field. All counters saturate and never wrap. A synchronous reset clears them.

Software-facing logic reads any counter in a single transfer. The transmit bank and the receive bank each have their own request, acknowledge and read-data lines, and one address bus is shared by both. Each bank's read port is a two-state machine. `RD_IDLE` goes to `RD_ACK` when a request is seen. `RD_ACK` stays in `RD_ACK` while requests keep arriving and returns to `RD_IDLE` when no request is present. The acknowledge is therefore high exactly one cycle after each request. The counter value is captured at the request edge, so a read that coincides with an update returns the value from before the update. The counter width `CNT_W` is a parameter with a legal range of 16 to 40 bits.

Top module: `eth_stat_bank`

## Requirements
- R1: After a synchronous reset, every counter of both banks reads as zero.
- R2: On a cycle where the valid strobe of a bank is high, each flag counter of that bank whose vector bit is 1 increments by exactly one, and every flag counter whose bit is 0 keeps its value. On cycles where the valid strobe is low, no counter of that bank changes, whatever the vector holds.
- R3: On an accepted vector, the bank's byte counter adds the unsigned value of vector bits 13..0.
- R4: A counter that would pass all ones (2^CNT_W-1) holds at all ones instead, and it stays there on later updates.
- R5: Address 0 selects the byte counter. Address k, for k = 1 to 12, selects the flag counter fed by vector bit 13+k: 1 is transmit/receive OK (bit 14), 2 is control inserted by MAC (bit 15), 3 is control inserted by client (bit 16), 4 is jumbo (bit 17), 5 is tagged (bit 18), 6 is broadcast (bit 19), 7 is multicast (bit 20), 8 is underrun (bit 21), 9 is CRC error (bit 22), 10 is length check error (bit 23), 11 is terminate error (bit 24) and 12 is long frame error (bit 25).
- R6: A read of an unmapped address (13 to 15) is acknowledged normally and returns zero data.
- R7: A bank's acknowledge is high in exactly the cycle after each cycle in which its request is high, and never otherwise. The read data holds the counter value while acknowledge is high and is zero while it is low.
- R8: When a read request and a vector update hit the same counter in the same cycle, the acknowledged data is the value from before that update. A later read returns the updated value.
- R9: The transmit and receive banks count and answer independently. Requests on both channels in the same cycle are both served from the shared address. A request on one channel produces no acknowledge on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_vec_valid | input | 1 | Transmit statistics vector strobe |
| tx_vec | input | 26 | Transmit statistics vector (flags 25..14, byte count 13..0) |
| rx_vec_valid | input | 1 | Receive statistics vector strobe |
| rx_vec | input | 26 | Receive statistics vector, same layout |
| stat_addr | input | 4 | Counter address shared by both read channels |
| tx_rd_req | input | 1 | Transmit bank read request |
| tx_rd_ack | output | 1 | Transmit bank read acknowledge |
| tx_rd_data | output | CNT_W | Transmit bank read data |
| rx_rd_req | input | 1 | Receive bank read request |
| rx_rd_ack | output | 1 | Receive bank read acknowledge |
| rx_rd_data | output | CNT_W | Receive bank read data |

## Verification
Several properties are checked on every cycle by assertions: each read acknowledge follows its request by exactly one cycle and never appears without one, unmapped reads return zero, a counter never decreases, a counter at all ones stays there, and a counter whose increment is zero keeps its value. What the assertions cannot show is checked by the bench's scenarios. These are the correct counter behind each address, exact byte sums, the pre-update value returned when a read and an update collide, saturation at the 16-bit limit for both byte and flag counters, and the independence of the two banks under the shared address.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;
    localparam int LEN_W     = 14;
    localparam int NUM_FLAGS = 12;
    localparam int VEC_W     = LEN_W + NUM_FLAGS;
    localparam int NUM_CNT   = NUM_FLAGS + 1;
    localparam int ADDR_W    = $clog2(NUM_CNT);

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_ACK  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/eth_stat_counter.sv
module eth_stat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT_VAL = '1;
    localparam int               PAD_W   = CNT_W + 1 - INC_W;

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {{PAD_W{1'b0}}, inc};
    end

    // Saturating accumulate
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sum[CNT_W]) begin
            cnt <= SAT_VAL;
        end else begin
            cnt <= sum[CNT_W-1:0];
        end
    end

    // Checker history
    logic             armed;
    logic [CNT_W-1:0] prev_cnt;
    logic             prev_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
        prev_cnt  <= cnt;
        prev_idle <= (inc == '0);
    end

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt >= prev_cnt));

    a_r4_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_cnt == SAT_VAL) |-> (cnt == SAT_VAL));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_idle) |-> (cnt == prev_cnt));
endmodule

// File: rtl/eth_stat_side.sv
module eth_stat_side
    import eth_stat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic [CNT_W-1:0]  rd_data
);
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];
    logic [LEN_W-1:0] byte_inc;

    always_comb begin
        byte_inc = vec_valid ? vec[LEN_W-1:0] : '0;
    end

    eth_stat_counter #(
        .CNT_W(CNT_W),
        .INC_W(LEN_W)
    ) u_byte_cnt (
        .clk(clk),
        .rst(rst),
        .inc(byte_inc),
        .cnt(cnt_arr[0])
    );

    // One counter per flag bit, address k+1 fed by bit LEN_W+k
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        logic flag_inc;

        always_comb begin
            flag_inc = vec_valid & vec[LEN_W+k];
        end

        eth_stat_counter #(
            .CNT_W(CNT_W),
            .INC_W(1)
        ) u_flag_cnt (
            .clk(clk),
            .rst(rst),
            .inc(flag_inc),
            .cnt(cnt_arr[k+1])
        );
    end

    // Read select
    logic [CNT_W-1:0] sel_val;
    logic             sel_hit;

    always_comb begin
        sel_val = '0;
        sel_hit = 1'b0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                sel_val = cnt_arr[i];
                sel_hit = 1'b1;
            end
        end
    end

    // Read port state machine
    rd_state_e        state_q;
    rd_state_e        state_d;
    logic [CNT_W-1:0] data_q;
    logic             hit_q;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_ACK : RD_IDLE;
            RD_ACK:  state_d = rd_req ? RD_ACK : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_req) begin
                data_q <= sel_val;
                hit_q  <= sel_hit;
            end
        end
    end

    always_comb begin
        rd_ack  = (state_q == RD_ACK);
        rd_data = rd_ack ? data_q : '0;
    end

    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_ack);

    a_r7_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_ack);

    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !hit_q) |-> (rd_data == '0));
endmodule

// File: rtl/eth_stat_bank.sv
module eth_stat_bank
    import eth_stat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_vec_valid,
    input  logic [VEC_W-1:0]  tx_vec,
    input  logic              rx_vec_valid,
    input  logic [VEC_W-1:0]  rx_vec,
    input  logic [ADDR_W-1:0] stat_addr,
    input  logic              tx_rd_req,
    output logic              tx_rd_ack,
    output logic [CNT_W-1:0]  tx_rd_data,
    input  logic              rx_rd_req,
    output logic              rx_rd_ack,
    output logic [CNT_W-1:0]  rx_rd_data
);
    eth_stat_side #(.CNT_W(CNT_W)) u_tx_side (
        .clk      (clk),
        .rst      (rst),
        .vec_valid(tx_vec_valid),
        .vec      (tx_vec),
        .rd_addr  (stat_addr),
        .rd_req   (tx_rd_req),
        .rd_ack   (tx_rd_ack),
        .rd_data  (tx_rd_data)
    );

    eth_stat_side #(.CNT_W(CNT_W)) u_rx_side (
        .clk      (clk),
        .rst      (rst),
        .vec_valid(rx_vec_valid),
        .vec      (rx_vec),
        .rd_addr  (stat_addr),
        .rd_req   (rx_rd_req),
        .rd_ack   (rx_rd_ack),
        .rd_data  (rx_rd_data)
    );
endmodule

// File: tb/eth_stat_bank_bench.sv
module eth_stat_bank_bench;
    localparam int BW   = 16;
    localparam int MAXV = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_vec_valid = 1'b0;
    logic [25:0]   tx_vec = '0;
    logic          rx_vec_valid = 1'b0;
    logic [25:0]   rx_vec = '0;
    logic [3:0]    stat_addr = '0;
    logic          tx_rd_req = 1'b0;
    logic          tx_rd_ack;
    logic [BW-1:0] tx_rd_data;
    logic          rx_rd_req = 1'b0;
    logic          rx_rd_ack;
    logic [BW-1:0] rx_rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_tx [13];
    int exp_rx [13];

    always #10 clk = ~clk;

    eth_stat_bank #(.CNT_W(BW)) u_eth_stat_bank (
        .clk(clk), .rst(rst),
        .tx_vec_valid(tx_vec_valid), .tx_vec(tx_vec),
        .rx_vec_valid(rx_vec_valid), .rx_vec(rx_vec),
        .stat_addr(stat_addr),
        .tx_rd_req(tx_rd_req), .tx_rd_ack(tx_rd_ack), .tx_rd_data(tx_rd_data),
        .rx_rd_req(rx_rd_req), .rx_rd_ack(rx_rd_ack), .rx_rd_data(rx_rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat_add(input int a, input int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic model_apply(input bit rx, input logic [25:0] v);
        for (int k = 0; k < 12; k++) begin
            if (v[14+k]) begin
                if (rx) exp_rx[k+1] = sat_add(exp_rx[k+1], 1);
                else    exp_tx[k+1] = sat_add(exp_tx[k+1], 1);
            end
        end
        if (rx) exp_rx[0] = sat_add(exp_rx[0], int'(v[13:0]));
        else    exp_tx[0] = sat_add(exp_tx[0], int'(v[13:0]));
    endtask

    // Drive one cycle of vectors; starts and ends at a falling edge
    task automatic send(input bit tv, input logic [25:0] tvec,
                        input bit rv, input logic [25:0] rvec);
        tx_vec_valid = tv; tx_vec = tvec;
        rx_vec_valid = rv; rx_vec = rvec;
        if (tv) model_apply(1'b0, tvec);
        if (rv) model_apply(1'b1, rvec);
        @(negedge clk);
        tx_vec_valid = 1'b0;
        rx_vec_valid = 1'b0;
    endtask

    // Read with ack timing checks (R7)
    task automatic rd(input logic [3:0] a, input bit ut, input bit ur,
                      output int tdat, output int rdat);
        stat_addr = a; tx_rd_req = ut; rx_rd_req = ur;
        @(negedge clk);
        check("R7 tx ack after req", int'(tx_rd_ack), int'(ut));
        check("R9 rx ack after req", int'(rx_rd_ack), int'(ur));
        tdat = int'(tx_rd_data);
        rdat = int'(rx_rd_data);
        tx_rd_req = 1'b0; rx_rd_req = 1'b0;
        @(negedge clk);
        check("R7 tx ack drops", int'(tx_rd_ack), 0);
        check("R7 rx ack drops", int'(rx_rd_ack), 0);
        check("R7 tx data zero idle", int'(tx_rd_data), 0);
        check("R7 rx data zero idle", int'(rx_rd_data), 0);
    endtask

    task automatic check_all(input string tag);
        int t, r;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), 1'b1, 1'b1, t, r);
            check({tag, " tx"}, t, (a < 13) ? exp_tx[a] : 0);
            check({tag, " rx"}, r, (a < 13) ? exp_rx[a] : 0);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 13; i++) begin exp_tx[i] = 0; exp_rx[i] = 0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset zero");
    endtask

    task automatic t_single_flags;
        int t, r;
        for (int k = 0; k < 12; k++) begin
            send(1'b1, 26'(1) << (14 + k), 1'b0, '0);
        end
        for (int a = 1; a < 13; a++) begin
            rd(4'(a), 1'b1, 1'b0, t, r);
            check("R5 flag address map", t, 1);
        end
        check_all("R2 single flags");
    endtask

    task automatic t_bytes;
        int t, r;
        send(1'b1, {12'h001, 14'd100}, 1'b0, '0);
        send(1'b1, {12'h000, 14'd1500}, 1'b0, '0);
        send(1'b1, {12'h400, 14'd64}, 1'b0, '0);
        rd(4'd0, 1'b1, 1'b0, t, r);
        check("R3 byte sum", t, 1664);
    endtask

    task automatic t_multi_rx;
        send(1'b0, '0, 1'b1, {12'b1010_0101_1100, 14'd333});
        send(1'b1, {12'b0000_0011_0001, 14'd9}, 1'b1, {12'b1111_1111_1111, 14'd16383});
        check_all("R9 independent banks");
    endtask

    task automatic t_idle;
        tx_vec = '1; rx_vec = '1;
        repeat (5) @(negedge clk);
        check_all("R2 no valid no change");
    endtask

    task automatic t_unmapped;
        int t, r;
        for (int a = 13; a < 16; a++) begin
            rd(4'(a), 1'b1, 1'b1, t, r);
            check("R6 unmapped tx zero", t, 0);
            check("R6 unmapped rx zero", r, 0);
        end
    endtask

    task automatic t_collision;
        int old_v, t, r;
        old_v = exp_tx[1];
        stat_addr = 4'd1; tx_rd_req = 1'b1;
        send(1'b1, {12'h001, 14'd5}, 1'b0, '0);
        check("R8 ack on collision", int'(tx_rd_ack), 1);
        check("R8 pre-update value", int'(tx_rd_data), old_v);
        tx_rd_req = 1'b0;
        @(negedge clk);
        rd(4'd1, 1'b1, 1'b0, t, r);
        check("R8 updated value", t, old_v + 1);
    endtask

    task automatic t_tx_only;
        int t, r;
        rd(4'd0, 1'b1, 1'b0, t, r);
        check("R9 tx only data", t, exp_tx[0]);
        rd(4'd0, 1'b0, 1'b1, t, r);
        check("R9 rx only data", r, exp_rx[0]);
    endtask

    task automatic t_sat_bytes;
        int t, r;
        for (int i = 0; i < 5; i++) send(1'b0, '0, 1'b1, {12'h000, 14'd16383});
        rd(4'd0, 1'b0, 1'b1, t, r);
        check("R4 byte saturate", r, MAXV);
        send(1'b0, '0, 1'b1, {12'h000, 14'd7});
        rd(4'd0, 1'b0, 1'b1, t, r);
        check("R4 byte stays saturated", r, MAXV);
    endtask

    task automatic t_sat_flag;
        int t, r;
        for (int i = 0; i < MAXV + 5; i++) send(1'b1, {12'h001, 14'd0}, 1'b0, '0);
        rd(4'd1, 1'b1, 1'b0, t, r);
        check("R4 flag saturate", t, MAXV);
        check_all("R4 bank after saturation");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_flags();
        t_bytes();
        t_multi_rx();
        t_idle();
        t_unmapped();
        t_collision();
        t_tx_only();
        t_sat_bytes();
        t_sat_flag();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule